// File: doc/BRIEF.md
# UV Sensor Bring-Up and Polling Sequencer

This block sits on the host side of a two-wire serial bus and controls a UV light sensor through a byte-level bus controller. The controller offers four operations: a START condition, a byte write, a byte read and a STOP condition. The sequencer issues these operations one at a time and waits for each to finish. After reset it first clears any alert the sensor is holding, which it does with a read at the alert-response address. It then writes the sensor's power-up command byte. From that point it accepts new command bytes and read requests.

A measurement always takes two separate bus transactions. The upper byte comes first, then the lower byte. The 16-bit value is published with a one-cycle strobe. In alert mode, a raised alert input starts an alert-clear read followed by a measurement. In polling mode the alert input is ignored, and every command write or measurement is preceded by an alert-clear read. A missing acknowledge on an address byte ends the current sequence with a STOP and sets a sticky error flag. A second sticky flag reports that start-up did not finish within a set number of cycles.

Top module: `uv_host_seq`

## Requirements
- R1: After reset release, the first bus transaction is an alert-clear read: START, write of address byte 0x19, one byte read, STOP.
- R2: The second transaction is START, write 0x70, write 0x06, STOP. After it, `initDone` rises and stays high until reset.
- R3: If `initDone` has not risen within INIT_LIMIT clock cycles of reset release, `initTimeout` rises and stays high. It never rises once start-up has completed.
- R4: A measurement is a read at address byte 0x73 followed by a read at 0x71. `uvData` becomes {first byte, second byte}, and `uvValid` pulses for exactly one cycle in the cycle `uvData` changes. `uvData` holds its value at all other times.
- R5: With `alertMode`=1, a high `alertIn` seen while idle starts an alert-clear read (0x19) followed by a measurement.
- R6: With `alertMode`=0, `alertIn` starts no bus activity. Each command write and each measurement is preceded by an alert-clear read at 0x19.
- R7: If an address byte is not acknowledged, the next operation is STOP, the remaining transactions of that sequence are dropped, and `nackErr` is set and stays set until reset.
- R8: A `cmdWrEn` pulse sends its byte as START, 0x70, byte, STOP. A write requested while another sequence is running waits until that sequence ends. If several writes arrive before it is sent, only the most recent byte is sent.
- R9: `busCmdValid` is a one-cycle pulse. A new operation is issued only after the previous one has reported `busOpDone`. Operation codes on `busCmdOp` are START=0, WRITE=1, READ=2, STOP=3.
- R10: When several requests are waiting in idle, they are served in this order: an alert (in alert mode) first, then a pending command write, then a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| alertMode | input | 1 | 1: alert-driven operation; 0: poll the alert-response address before each sequence |
| alertIn | input | 1 | Sensor alert, active high |
| rdReq | input | 1 | Pulse requesting one measurement |
| cmdWrEn | input | 1 | Pulse requesting a command write |
| cmdWrData | input | 8 | Command byte for the write |
| busCmdValid | output | 1 | One-cycle pulse issuing a bus operation |
| busCmdOp | output | 2 | Operation code: 0 START, 1 WRITE, 2 READ, 3 STOP |
| busCmdByte | output | 8 | Byte to send for a WRITE operation |
| busOpDone | input | 1 | Pulse from the bus controller when the operation has finished |
| busOpAck | input | 1 | Acknowledge received for the finished WRITE operation |
| busRdByte | input | 8 | Byte returned by the finished READ operation |
| uvData | output | 16 | Last complete measurement |
| uvValid | output | 1 | One-cycle strobe marking a new `uvData` |
| initDone | output | 1 | Start-up sequence completed |
| nackErr | output | 1 | Sticky flag: an address byte was not acknowledged |
| initTimeout | output | 1 | Sticky flag: start-up did not complete in time |

## Verification
Some properties are checked on every cycle: the single-cycle shape of the bus command and result strobes, that `uvData` does not change without `uvValid`, and that the two error flags and the start-up flag stay set once raised. Other behaviour can only be shown by the bench's scenarios, using a bus-controller model that checks each written byte against a scoreboard queue. This covers the exact byte order of start-up and of measurements, alert-clear polling, holding back writes raised mid-sequence, priority among pending requests, dropping a sequence after a missing acknowledge, and the start-up timeout.

// File: rtl/uv_host_seq_pkg.sv
package uv_host_seq_pkg;

  localparam int BYTE_W = 8;

  // bus operation codes seen by the byte-level controller
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } busOpE;

  // one transaction kind per job
  typedef enum logic [2:0] {
    J_ARA  = 3'd0,
    J_INIT = 3'd1,
    J_CMD  = 3'd2,
    J_MSB  = 3'd3,
    J_LSB  = 3'd4
  } jobE;

  // control-to-datapath strobes
  typedef struct packed {
    logic capMsb;
    logic capLsb;
    logic takeCmd;
    logic clrRdPend;
    logic setInit;
    logic setNack;
  } seqStrobeT;

  localparam logic [BYTE_W-1:0] ADDR_ALERT_RD = 8'h19;
  localparam logic [BYTE_W-1:0] ADDR_CMD_WR   = 8'h70;
  localparam logic [BYTE_W-1:0] ADDR_HI_RD    = 8'h73;
  localparam logic [BYTE_W-1:0] ADDR_LO_RD    = 8'h71;
  localparam logic [BYTE_W-1:0] BOOT_CMD      = 8'h06;

endpackage

// File: rtl/uv_host_seq_ctrl.sv
module uv_host_seq_ctrl
  import uv_host_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              alertMode,
  input  logic              alertIn,
  input  logic              pendWr,
  input  logic              rdPend,
  input  logic              initDone,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              busOpDone,
  input  logic              busOpAck,
  output logic              busCmdValid,
  output logic [1:0]        busCmdOp,
  output logic [BYTE_W-1:0] busCmdByte,
  output seqStrobeT         stb
);

  typedef enum logic [1:0] {S_BOOT, S_IDLE, S_ISSUE, S_WAIT} stateE;
  typedef enum logic [1:0] {P_START, P_ADDR, P_DATA, P_STOP} stepE;

  stateE state;
  stepE  step;
  jobE   job, nextJob;
  logic  hasNext, aborting;

  logic              isRead, opDone, alertGo, idleGo;
  logic [BYTE_W-1:0] addrByte, dataByte;
  busOpE             opSel;

  always_comb begin
    isRead   = (job == J_ARA) || (job == J_MSB) || (job == J_LSB);
    case (job)
      J_ARA:   addrByte = ADDR_ALERT_RD;
      J_MSB:   addrByte = ADDR_HI_RD;
      J_LSB:   addrByte = ADDR_LO_RD;
      default: addrByte = ADDR_CMD_WR;
    endcase
    dataByte = (job == J_INIT) ? BOOT_CMD : wrByte;
    opDone   = (state == S_WAIT) && busOpDone;
    alertGo  = alertMode && alertIn;
    idleGo   = (state == S_IDLE) && initDone;

    stb           = '0;
    stb.capMsb    = opDone && (step == P_DATA) && (job == J_MSB);
    stb.capLsb    = opDone && (step == P_DATA) && (job == J_LSB);
    stb.setNack   = opDone && (step == P_ADDR) && !busOpAck;
    stb.setInit   = opDone && (step == P_STOP) && !aborting && (job == J_INIT);
    stb.takeCmd   = idleGo && !alertGo && pendWr;
    stb.clrRdPend = idleGo && !alertGo && !pendWr && rdPend;

    case (step)
      P_START: opSel = OP_START;
      P_ADDR:  opSel = OP_WRITE;
      P_DATA:  opSel = isRead ? OP_READ : OP_WRITE;
      default: opSel = OP_STOP;
    endcase
    busCmdValid = (state == S_ISSUE);
    busCmdOp    = opSel;
    if (step == P_ADDR)                busCmdByte = addrByte;
    else if (step == P_DATA && !isRead) busCmdByte = dataByte;
    else                               busCmdByte = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_BOOT;
      step     <= P_START;
      job      <= J_ARA;
      nextJob  <= J_INIT;
      hasNext  <= 1'b0;
      aborting <= 1'b0;
    end else begin
      case (state)
        S_BOOT: begin
          job     <= J_ARA;
          nextJob <= J_INIT;
          hasNext <= 1'b1;
          step    <= P_START;
          state   <= S_ISSUE;
        end
        S_IDLE: begin
          if (idleGo) begin
            if (alertGo) begin
              job     <= J_ARA;
              nextJob <= J_MSB;
              hasNext <= 1'b1;
              step    <= P_START;
              state   <= S_ISSUE;
            end else if (pendWr) begin
              job     <= alertMode ? J_CMD : J_ARA;
              nextJob <= J_CMD;
              hasNext <= !alertMode;
              step    <= P_START;
              state   <= S_ISSUE;
            end else if (rdPend) begin
              job     <= alertMode ? J_MSB : J_ARA;
              nextJob <= J_MSB;
              hasNext <= !alertMode;
              step    <= P_START;
              state   <= S_ISSUE;
            end
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (busOpDone) begin
            state <= S_ISSUE;
            case (step)
              P_START: step <= P_ADDR;
              P_ADDR: begin
                if (!busOpAck) begin
                  aborting <= 1'b1;
                  step     <= P_STOP;
                end else begin
                  step <= P_DATA;
                end
              end
              P_DATA: step <= P_STOP;
              default: begin
                step <= P_START;
                if (aborting) begin
                  aborting <= 1'b0;
                  hasNext  <= 1'b0;
                  state    <= S_IDLE;
                end else if (job == J_MSB) begin
                  job <= J_LSB;
                end else if (hasNext) begin
                  job     <= nextJob;
                  hasNext <= 1'b0;
                end else begin
                  state <= S_IDLE;
                end
              end
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uv_host_seq_dpath.sv
module uv_host_seq_dpath
  import uv_host_seq_pkg::*;
#(
  parameter int INIT_LIMIT = 37_500_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobeT           stb,
  input  logic [BYTE_W-1:0]   busRdByte,
  input  logic                cmdWrEn,
  input  logic [BYTE_W-1:0]   cmdWrData,
  input  logic                rdReq,
  output logic                pendWr,
  output logic                rdPend,
  output logic [BYTE_W-1:0]   wrByte,
  output logic                initDone,
  output logic [2*BYTE_W-1:0] uvData,
  output logic                uvValid,
  output logic                nackErr,
  output logic                initTimeout
);

  localparam int CNT_W = $clog2(INIT_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_LIMIT - 1);

  logic [BYTE_W-1:0] pendData, msbHold;
  logic [CNT_W-1:0]  bootCnt;

  // pending command slot: newest write wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWr   <= 1'b0;
      pendData <= '0;
      wrByte   <= '0;
    end else begin
      if (stb.takeCmd) wrByte <= pendData;
      if (cmdWrEn) begin
        pendWr   <= 1'b1;
        pendData <= cmdWrData;
      end else if (stb.takeCmd) begin
        pendWr <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPend <= 1'b0;
    else if (rdReq) rdPend <= 1'b1;
    else if (stb.clrRdPend) rdPend <= 1'b0;
  end

  // result assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msbHold <= '0;
      uvData  <= '0;
      uvValid <= 1'b0;
    end else begin
      uvValid <= stb.capLsb;
      if (stb.capMsb) msbHold <= busRdByte;
      if (stb.capLsb) uvData <= {msbHold, busRdByte};
    end
  end

  // status flags and start-up watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initDone    <= 1'b0;
      nackErr     <= 1'b0;
      initTimeout <= 1'b0;
      bootCnt     <= '0;
    end else begin
      if (stb.setInit) initDone <= 1'b1;
      if (stb.setNack) nackErr <= 1'b1;
      if (!initDone && !stb.setInit && !initTimeout) begin
        if (bootCnt == CNT_LAST) initTimeout <= 1'b1;
        else bootCnt <= bootCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uv_host_seq.sv
module uv_host_seq
  import uv_host_seq_pkg::*;
#(
  parameter int INIT_LIMIT = 37_500_000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         alertMode,
  input  logic         alertIn,
  input  logic         rdReq,
  input  logic         cmdWrEn,
  input  logic [7:0]   cmdWrData,
  output logic         busCmdValid,
  output logic [1:0]   busCmdOp,
  output logic [7:0]   busCmdByte,
  input  logic         busOpDone,
  input  logic         busOpAck,
  input  logic [7:0]   busRdByte,
  output logic [15:0]  uvData,
  output logic         uvValid,
  output logic         initDone,
  output logic         nackErr,
  output logic         initTimeout
);

  seqStrobeT         stb;
  logic              pendWr, rdPend;
  logic [BYTE_W-1:0] wrByte;

  uv_host_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .alertMode   (alertMode),
    .alertIn     (alertIn),
    .pendWr      (pendWr),
    .rdPend      (rdPend),
    .initDone    (initDone),
    .wrByte      (wrByte),
    .busOpDone   (busOpDone),
    .busOpAck    (busOpAck),
    .busCmdValid (busCmdValid),
    .busCmdOp    (busCmdOp),
    .busCmdByte  (busCmdByte),
    .stb         (stb)
  );

  uv_host_seq_dpath #(.INIT_LIMIT(INIT_LIMIT)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .busRdByte   (busRdByte),
    .cmdWrEn     (cmdWrEn),
    .cmdWrData   (cmdWrData),
    .rdReq       (rdReq),
    .pendWr      (pendWr),
    .rdPend      (rdPend),
    .wrByte      (wrByte),
    .initDone    (initDone),
    .uvData      (uvData),
    .uvValid     (uvValid),
    .nackErr     (nackErr),
    .initTimeout (initTimeout)
  );

endmodule

// File: rtl/uv_host_seq_chk.sv
module uv_host_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busCmdValid,
  input logic [15:0] uvData,
  input logic        uvValid,
  input logic        initDone,
  input logic        nackErr,
  input logic        initTimeout
);

  // R9
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    busCmdValid |=> !busCmdValid);

  // R4
  uv_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    uvValid |=> !uvValid);

  // R4
  uv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !uvValid |-> $stable(uvData));

  // R7
  nack_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    nackErr |=> nackErr);

  // R3
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initTimeout |=> initTimeout);

  // R3
  tmo_no_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> !$rose(initTimeout));

  // R2
  init_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

endmodule

bind uv_host_seq uv_host_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busCmdValid (busCmdValid),
  .uvData      (uvData),
  .uvValid     (uvValid),
  .initDone    (initDone),
  .nackErr     (nackErr),
  .initTimeout (initTimeout)
);

// File: tb/uv_host_seq_tb.sv
`timescale 1ns/1ps
module uv_host_seq_tb;

  localparam int LIMIT = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic alertMode = 1'b1, alertIn, rdReq = 1'b0, cmdWrEn = 1'b0;
  logic [7:0] cmdWrData = '0;
  logic busCmdValid;
  logic [1:0] busCmdOp;
  logic [7:0] busCmdByte;
  logic busOpDone, busOpAck;
  logic [7:0] busRdByte;
  logic [15:0] uvData;
  logic uvValid, initDone, nackErr, initTimeout;

  always #2 clk = ~clk;

  uv_host_seq #(.INIT_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .alertMode(alertMode), .alertIn(alertIn),
    .rdReq(rdReq), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .busCmdValid(busCmdValid), .busCmdOp(busCmdOp), .busCmdByte(busCmdByte),
    .busOpDone(busOpDone), .busOpAck(busOpAck), .busRdByte(busRdByte),
    .uvData(uvData), .uvValid(uvValid), .initDone(initDone),
    .nackErr(nackErr), .initTimeout(initTimeout)
  );

  int nChecks = 0, nFails = 0, cmdCount = 0;
  logic [7:0]  expWr[$];
  string       expTag[$];
  logic [15:0] expRes[$];
  logic [15:0] sensVal = 16'h0000;
  logic nackNext = 1'b0, alertCmd = 1'b0;

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic pushW(input logic [7:0] b, input string tag);
    expWr.push_back(b);
    expTag.push_back(tag);
  endtask

  // bus controller and sensor model with write-byte scoreboard
  logic [2:0] engCnt;
  logic [1:0] engOp;
  logic [7:0] engByte, curAddr, ex;
  logic nextIsAddr, mustStop;
  string tx;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOpDone <= 1'b0; busOpAck <= 1'b0; busRdByte <= '0;
      engCnt <= '0; engOp <= '0; engByte <= '0; curAddr <= '0;
      nextIsAddr <= 1'b0; mustStop <= 1'b0; alertIn <= 1'b0;
    end else begin
      busOpDone <= 1'b0;
      if (alertCmd) alertIn <= 1'b1;
      if (busCmdValid) begin
        cmdCount++;
        check(engCnt == 0, "R9 one operation outstanding", engCnt, 0);
        if (mustStop) begin
          check(busCmdOp == 2'd3, "R7 STOP after missing ack", busCmdOp, 3);
          mustStop <= 1'b0;
        end
        if (busCmdOp == 2'd1) begin
          if (expWr.size() == 0) check(1'b0, "R9 unexpected write byte", busCmdByte, 0);
          else begin
            ex = expWr.pop_front();
            tx = expTag.pop_front();
            check(busCmdByte == ex, tx, busCmdByte, ex);
          end
        end
        engOp <= busCmdOp; engByte <= busCmdByte; engCnt <= 3'd3;
      end else if (engCnt != 0) begin
        engCnt <= engCnt - 1'b1;
        if (engCnt == 3'd1) begin
          busOpDone <= 1'b1;
          busOpAck  <= 1'b1;
          case (engOp)
            2'd0: nextIsAddr <= 1'b1;
            2'd1: if (nextIsAddr) begin
              nextIsAddr <= 1'b0;
              curAddr    <= engByte;
              if (nackNext) begin busOpAck <= 1'b0; mustStop <= 1'b1; end
            end
            2'd2: begin
              busRdByte <= (curAddr == 8'h73) ? sensVal[15:8] :
                           (curAddr == 8'h71) ? sensVal[7:0] : 8'h70;
              if (curAddr == 8'h19) alertIn <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // result monitor
  logic [15:0] er;
  always @(negedge clk) begin
    if (rstN && uvValid) begin
      if (expRes.size() == 0) check(1'b0, "R4 unexpected result strobe", uvData, 0);
      else begin
        er = expRes.pop_front();
        check(uvData == er, "R4 assembled result", uvData, er);
      end
    end
  end

  task automatic drain(input string what);
    int n = 0;
    while ((expWr.size() != 0 || expRes.size() != 0) && n < 3000) begin
      @(negedge clk); n++;
    end
    repeat (30) @(negedge clk);
    check(expWr.size() == 0 && expRes.size() == 0, what, expWr.size() + expRes.size(), 0);
  endtask

  task automatic pulseRd();
    @(negedge clk) rdReq = 1'b1;
    @(negedge clk) rdReq = 1'b0;
  endtask

  task automatic pulseWr(input logic [7:0] b);
    @(negedge clk) begin cmdWrEn = 1'b1; cmdWrData = b; end
    @(negedge clk) cmdWrEn = 1'b0;
  endtask

  task automatic pulseAlert();
    @(negedge clk) alertCmd = 1'b1;
    @(negedge clk) alertCmd = 1'b0;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int c0;
    // reset state
    repeat (3) @(negedge clk);
    check(!busCmdValid && !uvValid, "R9 quiet in reset", {busCmdValid, uvValid}, 0);
    check(!initDone && !nackErr && !initTimeout, "R2 flags clear in reset",
          {initDone, nackErr, initTimeout}, 0);
    pushW(8'h19, "R1 alert clear first");
    pushW(8'h70, "R2 boot command address");
    pushW(8'h06, "R2 boot command value");
    rstN = 1'b1;
    drain("R1 boot sequence complete");
    check(initDone == 1'b1, "R2 initDone after boot", initDone, 1);
    check(initTimeout == 1'b0, "R3 no timeout after boot", initTimeout, 0);

    // plain measurement
    sensVal = 16'hA51C;
    pushW(8'h73, "R4 upper byte first"); pushW(8'h71, "R4 lower byte second");
    expRes.push_back(16'hA51C);
    pulseRd();
    drain("R4 measurement");

    // alert-driven
    sensVal = 16'h1234;
    pushW(8'h19, "R5 alert clear"); pushW(8'h73, "R5 upper"); pushW(8'h71, "R5 lower");
    expRes.push_back(16'h1234);
    pulseAlert();
    drain("R5 alert sequence");

    // writes during a read are held, newest wins
    sensVal = 16'h00FF;
    pushW(8'h73, "R8 read first"); pushW(8'h71, "R8 read first");
    pushW(8'h70, "R8 held write address"); pushW(8'h0E, "R8 newest byte");
    expRes.push_back(16'h00FF);
    pulseRd();
    repeat (4) @(negedge clk);
    pulseWr(8'h0C);
    pulseWr(8'h0E);
    drain("R8 held write");

    // priority: alert, then write, then read
    sensVal = 16'hBEEF;
    pushW(8'h70, "R10 running write"); pushW(8'h08, "R10 running write");
    pushW(8'h19, "R10 alert first"); pushW(8'h73, "R10 alert read"); pushW(8'h71, "R10 alert read");
    pushW(8'h70, "R10 write second"); pushW(8'h0A, "R10 write second");
    pushW(8'h73, "R10 read last"); pushW(8'h71, "R10 read last");
    expRes.push_back(16'hBEEF); expRes.push_back(16'hBEEF);
    pulseWr(8'h08);
    repeat (3) @(negedge clk);
    pulseRd();
    pulseAlert();
    pulseWr(8'h0A);
    drain("R10 priority order");

    // polling mode
    @(negedge clk) alertMode = 1'b0;
    c0 = cmdCount;
    pulseAlert();
    repeat (100) @(negedge clk);
    check(cmdCount == c0, "R6 alert ignored when polling", cmdCount - c0, 0);
    sensVal = 16'h7E01;
    pushW(8'h19, "R6 poll before read"); pushW(8'h73, "R6 upper"); pushW(8'h71, "R6 lower");
    expRes.push_back(16'h7E01);
    pulseRd();
    drain("R6 polled read");
    pushW(8'h19, "R6 poll before write"); pushW(8'h70, "R6 write"); pushW(8'h02, "R6 write");
    pulseWr(8'h02);
    drain("R6 polled write");

    // missing acknowledge
    @(negedge clk) begin alertMode = 1'b1; nackNext = 1'b1; end
    pushW(8'h73, "R7 refused address");
    pulseRd();
    repeat (60) @(negedge clk);
    nackNext = 1'b0;
    check(nackErr == 1'b1, "R7 nackErr set", nackErr, 1);
    check(expWr.size() == 0, "R7 sequence dropped", expWr.size(), 0);
    sensVal = 16'h4242;
    pushW(8'h73, "R7 later read"); pushW(8'h71, "R7 later read");
    expRes.push_back(16'h4242);
    pulseRd();
    drain("R7 recovers");
    check(nackErr == 1'b1, "R7 nackErr sticky", nackErr, 1);
    repeat (LIMIT) @(negedge clk);
    check(initTimeout == 1'b0, "R3 no timeout once started", initTimeout, 0);

    // start-up timeout: boot alert clear refused
    @(negedge clk) rstN = 1'b0;
    nackNext = 1'b1;
    pushW(8'h19, "R7 refused at boot");
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (LIMIT - 40) @(negedge clk);
    check(initTimeout == 1'b0, "R3 not early", initTimeout, 0);
    repeat (80) @(negedge clk);
    check(initTimeout == 1'b1, "R3 timeout raised", initTimeout, 1);
    check(initDone == 1'b0 && nackErr == 1'b1, "R3 boot stalled", {initDone, nackErr}, 1);
    check(expWr.size() == 0, "R1 boot alert clear issued", expWr.size(), 0);
    finishRun();
  end

endmodule